// File: doc/BRIEF.md
# Dual-Mode Distributed LUT RAM

This block is a tiny read/write store made of two 16-cell, one-bit lookup tables, called F and G, each addressed by its own four address lines. A static organisation input decides how two shared control pins are used. In wide organisation the pair is treated as a 16-word by 2-bit memory: the two control pins carry one data bit for each table, and a common write strobe writes both tables at once. In deep organisation the tables act as one 32-word by 1-bit memory: one control pin becomes the fifth address bit that chooses which table is written and read, and the other carries the single data bit.

Reads are purely combinational. Each table output can leave the block straight from the cell or through an output flip-flop, chosen per output by a select pin. A deep-organisation output returns the 32x1 read, and a combining output applies an 8-entry truth table to the F read, the G read and the high control pin. To use the deep organisation as a true 32x1 memory, the integrator drives the same four-bit address onto both address buses.

Top module: `lutram_dual`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all 32 cells and both output flip-flops to 0.
- R2: With its pipe select low, f_out equals the F cell at f_addr and g_out equals the G cell at g_addr, in the same cycle and with no clock edge in between.
- R3: In wide organisation (cfg_deep = 0), a rising edge with wr_en high writes ctl_lo into F[f_addr] and ctl_hi into G[g_addr].
- R4: A rising edge with wr_en low changes no cell, whatever the data, address and control pins carry.
- R5: In deep organisation (cfg_deep = 1), a write with ctl_hi = 0 stores ctl_lo into F[f_addr] only, and a write with ctl_hi = 1 stores ctl_lo into G[g_addr] only. The other table is left unchanged.
- R6: deep_out equals the combinational F read when ctl_hi is 0 and the combinational G read when ctl_hi is 1, in both organisations.
- R7: With f_pipe high, f_out shows the F read that was present just before the previous rising edge, and g_pipe does the same for g_out.
- R8: h_out equals h_tbl at bit index 4*ctl_hi + 2*(G read) + (F read), using the combinational reads.
- R9: In a cycle that writes a cell, the read of that cell still returns the old contents until the edge. The new value appears after the edge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells and output flops update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_deep | input | 1 | Organisation: 0 = 16x2 wide, 1 = 32x1 deep |
| f_addr | input | 4 | Cell address of table F |
| g_addr | input | 4 | Cell address of table G |
| ctl_hi | input | 1 | G data bit (wide) or fifth address bit (deep) |
| ctl_lo | input | 1 | F data bit (wide) or the single data bit (deep) |
| wr_en | input | 1 | Write strobe |
| f_pipe | input | 1 | 1 = f_out taken from its output flip-flop |
| g_pipe | input | 1 | 1 = g_out taken from its output flip-flop |
| h_tbl | input | 8 | Truth table of the combining function |
| f_out | output | 1 | F read, direct or registered |
| g_out | output | 1 | G read, direct or registered |
| deep_out | output | 1 | 32x1 read selected by ctl_hi |
| h_out | output | 1 | Combining function result |

## Verification
The assertions check the local rules on every cycle. They cover the output-flop delay, the clearing of both output flops by reset, the steering of deep_out and h_out by ctl_hi, how a wide-organisation write lands in both tables, and the untouched table in a deep write whenever the address is held. Only the bench's scenarios show that every one of the 32 cells keeps its value over long stretches, that a reset clears cells nobody is reading, and that deep writes followed by reads with other addresses match a full array model. These scenarios also cover the same-cycle old-value read around a write.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    localparam int CELL_AW   = 4;
    localparam int H_INPUTS  = 3;
    localparam int H_ENTRIES = 1 << H_INPUTS;

    typedef enum logic {
        ORG_WIDE = 1'b0,
        ORG_DEEP = 1'b1
    } org_e;

    typedef struct packed {
        logic we_f;
        logic we_g;
        logic din_f;
        logic din_g;
    } wr_ctl_t;

    typedef struct packed {
        logic g;
        logic f;
    } rd_pair_t;

    function automatic wr_ctl_t map_write(org_e org, logic we, logic hi, logic lo);
        wr_ctl_t w;
        if (org == ORG_DEEP) begin
            w.we_f  = we & ~hi;
            w.we_g  = we & hi;
            w.din_f = lo;
            w.din_g = lo;
        end else begin
            w.we_f  = we;
            w.we_g  = we;
            w.din_f = lo;
            w.din_g = hi;
        end
        return w;
    endfunction

    function automatic logic h_eval(logic [H_ENTRIES-1:0] tbl, logic hi, rd_pair_t rd);
        return tbl[{hi, rd.g, rd.f}];
    endfunction

endpackage

// File: rtl/lutram_cell.sv
module lutram_cell #(
    parameter int AW           = 4,
    parameter bit CLEAR_ON_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          din,
    input  logic [AW-1:0] addr,
    output logic          rd
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] bits;

    if (CLEAR_ON_RST) begin : g_clr
        always_ff @(posedge clk) begin
            if (rst) begin
                bits <= '0;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (we && addr == AW'(i)) bits[i] <= din;
                end
            end
        end
    end else begin : g_keep
        always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!rst && we && addr == AW'(i)) bits[i] <= din;
            end
        end
    end

    assign rd = bits[addr];

endmodule

// File: rtl/lutram_ctl.sv
module lutram_ctl
    import lutram_pkg::*;
(
    input  logic    cfg_deep,
    input  logic    wr_en,
    input  logic    ctl_hi,
    input  logic    ctl_lo,
    output wr_ctl_t wr
);
    org_e org;

    always_comb begin
        org = cfg_deep ? ORG_DEEP : ORG_WIDE;
        wr  = map_write(org, wr_en, ctl_hi, ctl_lo);
    end

endmodule

// File: rtl/lutram_tap.sv
module lutram_tap (
    input  logic clk,
    input  logic rst,
    input  logic use_reg,
    input  logic d,
    output logic q
);
    logic held;

    always_ff @(posedge clk) begin
        if (rst) held <= 1'b0;
        else     held <= d;
    end

    assign q = use_reg ? held : d;

endmodule

// File: rtl/lutram_dual.sv
module lutram_dual
    import lutram_pkg::*;
#(
    parameter int AW           = lutram_pkg::CELL_AW,
    parameter bit CLEAR_ON_RST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_deep,
    input  logic [AW-1:0]        f_addr,
    input  logic [AW-1:0]        g_addr,
    input  logic                 ctl_hi,
    input  logic                 ctl_lo,
    input  logic                 wr_en,
    input  logic                 f_pipe,
    input  logic                 g_pipe,
    input  logic [H_ENTRIES-1:0] h_tbl,
    output logic                 f_out,
    output logic                 g_out,
    output logic                 deep_out,
    output logic                 h_out
);
    localparam int NTAB = 2;

    wr_ctl_t  wr;
    rd_pair_t rd_raw;

    logic [AW-1:0] tab_addr [NTAB];
    logic          tab_we   [NTAB];
    logic          tab_din  [NTAB];
    logic          tab_rd   [NTAB];
    logic          tab_pipe [NTAB];
    logic          tab_out  [NTAB];

    lutram_ctl u_ctl (
        .cfg_deep (cfg_deep),
        .wr_en    (wr_en),
        .ctl_hi   (ctl_hi),
        .ctl_lo   (ctl_lo),
        .wr       (wr)
    );

    always_comb begin
        tab_addr[0] = f_addr;  tab_addr[1] = g_addr;
        tab_we[0]   = wr.we_f; tab_we[1]   = wr.we_g;
        tab_din[0]  = wr.din_f; tab_din[1] = wr.din_g;
        tab_pipe[0] = f_pipe;  tab_pipe[1] = g_pipe;
    end

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        lutram_cell #(.AW(AW), .CLEAR_ON_RST(CLEAR_ON_RST)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .we   (tab_we[t]),
            .din  (tab_din[t]),
            .addr (tab_addr[t]),
            .rd   (tab_rd[t])
        );
        lutram_tap u_tap (
            .clk     (clk),
            .rst     (rst),
            .use_reg (tab_pipe[t]),
            .d       (tab_rd[t]),
            .q       (tab_out[t])
        );
    end

    always_comb begin
        rd_raw.f = tab_rd[0];
        rd_raw.g = tab_rd[1];
    end

    assign f_out    = tab_out[0];
    assign g_out    = tab_out[1];
    assign deep_out = ctl_hi ? rd_raw.g : rd_raw.f;
    assign h_out    = h_eval(h_tbl, ctl_hi, rd_raw);

endmodule

// File: rtl/lutram_dual_chk.sv
module lutram_dual_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_deep,
    input logic [AW-1:0] f_addr,
    input logic [AW-1:0] g_addr,
    input logic          ctl_hi,
    input logic          ctl_lo,
    input logic          wr_en,
    input logic          f_pipe,
    input logic          g_pipe,
    input logic [7:0]    h_tbl,
    input logic          f_out,
    input logic          g_out,
    input logic          deep_out,
    input logic          h_out,
    input logic          f_rd,
    input logic          g_rd
);

    AST_PIPE_CLEAR: assert property (@(posedge clk)
        rst |=> ((!f_pipe || !f_out) && (!g_pipe || !g_out))); // R1

    AST_WIDE_WRITE_F: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && !cfg_deep) && $stable(f_addr)) |-> (f_rd == $past(ctl_lo))); // R3

    AST_WIDE_WRITE_G: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && !cfg_deep) && $stable(g_addr)) |-> (g_rd == $past(ctl_hi))); // R3

    AST_NO_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(f_addr) && $stable(g_addr))
            |-> ($stable(f_rd) && $stable(g_rd))); // R4

    AST_DEEP_F_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_deep && wr_en && ctl_hi) && $stable(f_addr)) |-> $stable(f_rd)); // R5

    AST_DEEP_SELECT: assert property (@(posedge clk) disable iff (rst)
        (!f_pipe && !g_pipe) |-> (deep_out == (ctl_hi ? g_out : f_out))); // R6

    AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && f_pipe && g_pipe) |-> (f_out == $past(f_rd) && g_out == $past(g_rd))); // R7

    AST_H_TABLE: assert property (@(posedge clk) disable iff (rst)
        (!f_pipe && !g_pipe) |-> (h_out == h_tbl[{ctl_hi, g_out, f_out}])); // R8

endmodule

bind lutram_dual lutram_dual_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_deep (cfg_deep),
    .f_addr   (f_addr),
    .g_addr   (g_addr),
    .ctl_hi   (ctl_hi),
    .ctl_lo   (ctl_lo),
    .wr_en    (wr_en),
    .f_pipe   (f_pipe),
    .g_pipe   (g_pipe),
    .h_tbl    (h_tbl),
    .f_out    (f_out),
    .g_out    (g_out),
    .deep_out (deep_out),
    .h_out    (h_out),
    .f_rd     (rd_raw.f),
    .g_rd     (rd_raw.g)
);

// File: tb/sim_lutram_dual.sv
module sim_lutram_dual;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_deep = 1'b0;
    logic [3:0] f_addr = '0, g_addr = '0;
    logic       ctl_hi = 1'b0, ctl_lo = 1'b0, wr_en = 1'b0;
    logic       f_pipe = 1'b0, g_pipe = 1'b0;
    logic [7:0] h_tbl = '0;
    logic       f_out, g_out, deep_out, h_out;

    int  compared = 0;
    int  mismatched = 0;
    bit  valid = 1'b0;
    bit  done = 1'b0;
    logic mf [DEPTH];
    logic mg [DEPTH];
    logic qf = 1'b0, qg = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lutram_dual u0 (
        .clk(clk), .rst(rst), .cfg_deep(cfg_deep), .f_addr(f_addr), .g_addr(g_addr),
        .ctl_hi(ctl_hi), .ctl_lo(ctl_lo), .wr_en(wr_en), .f_pipe(f_pipe), .g_pipe(g_pipe),
        .h_tbl(h_tbl), .f_out(f_out), .g_out(g_out), .deep_out(deep_out), .h_out(h_out)
    );

    function automatic logic exp_h(logic [7:0] t, logic hi, logic g, logic f);
        return t[{hi, g, f}];
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(bit deep, logic [3:0] fa, logic [3:0] ga, bit hi, bit lo, bit we,
                        bit fp, bit gp, logic [7:0] ht, bit r, string tag);
        logic rf, rg;
        cfg_deep = deep; f_addr = fa; g_addr = ga; ctl_hi = hi; ctl_lo = lo;
        wr_en = we; f_pipe = fp; g_pipe = gp; h_tbl = ht; rst = r;
        #1;
        rf = mf[fa];
        rg = mg[ga];
        if (valid && !r) begin
            chk(fp ? "R7" : tag, "f_out", f_out, fp ? qf : rf);
            chk(gp ? "R7" : tag, "g_out", g_out, gp ? qg : rg);
            chk("R6", "deep_out", deep_out, hi ? rg : rf);
            chk("R8", "h_out", h_out, exp_h(ht, hi, rg, rf));
        end
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < DEPTH; i++) begin mf[i] = 1'b0; mg[i] = 1'b0; end
            qf = 1'b0; qg = 1'b0;
            valid = 1'b1;
        end else begin
            qf = rf; qg = rg;
            if (we) begin
                if (deep) begin
                    if (hi) mg[ga] = lo; else mf[fa] = lo;
                end else begin
                    mf[fa] = lo; mg[ga] = hi;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin mf[i] = 1'bx; mg[i] = 1'bx; end
        step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 1, "R1");
        // R1: every cell and both flops read zero after reset
        for (int a = 0; a < DEPTH; a++)
            step(a[0], 4'(a), 4'(15 - a), a[1], 0, 0, a[2], a[3], 8'hE8, 0, "R1");
        // R3 + R9: wide writes, same-cycle read returns old contents
        for (int a = 0; a < DEPTH; a++)
            step(0, 4'(a), 4'(a), a[0] ^ a[1], a[0], 1, 0, 0, 8'h96, 0, "R9");
        for (int a = 0; a < DEPTH; a++)
            step(0, 4'(a), 4'(a), 0, 0, 0, 0, 0, 8'h96, 0, "R3");
        // R4: strobe low with inverted data must change nothing
        for (int a = 0; a < DEPTH; a++)
            step(a[0], 4'(a), 4'(a), ~(a[0] ^ a[1]), ~a[0], 0, 0, 0, 8'h3C, 0, "R4");
        for (int a = 0; a < DEPTH; a++)
            step(0, 4'(a), 4'(a), 0, 0, 0, 0, 0, 8'h3C, 0, "R4");
        // R5: deep writes to G then F, with the other table checked afterwards
        for (int a = 0; a < DEPTH; a++)
            step(1, 4'(a), 4'(a), 1, 1, 1, 0, 0, 8'hF0, 0, "R9");
        for (int a = 0; a < DEPTH; a += 2)
            step(1, 4'(a), 4'(a), 0, 0, 1, 0, 0, 8'hCC, 0, "R9");
        for (int a = 0; a < DEPTH; a++) begin
            step(1, 4'(a), 4'(a), 0, 0, 0, 0, 0, 8'hAA, 0, "R5");
            step(1, 4'(a), 4'(a), 1, 0, 0, 0, 0, 8'hAA, 0, "R5");
        end
        // R7: registered outputs with changing addresses
        for (int a = 0; a < DEPTH; a++)
            step(0, 4'(a), 4'(DEPTH - 1 - a), 0, 0, 0, 1, 1, 8'h81, 0, "R7");
        // R2 + R8: constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] v;
            v = $urandom;
            step(v[0], v[4:1], v[8:5], v[9], v[10], v[13:11] < 3'd3,
                 v[14] & v[15], v[16] & v[17], v[25:18], 0, "R2");
        end
        // R1: mid-run reset clears written contents
        step(0, 0, 0, 1, 1, 1, 0, 0, 8'h00, 1, "R1");
        for (int a = 0; a < DEPTH; a++)
            step(1, 4'(a), 4'(a), a[0], 0, 0, a[1], a[1], 8'hFF, 0, "R1");
        finish_run();
    end

endmodule